// File: doc/BRIEF.md
# Read-Acquire Hardware Semaphore

This block is a single-bit hardware lock that lets several independent processors share one peripheral without any software handshake between them. Each processor reaches the block over a byte-wide register bus. Reading the semaphore status byte is the acquire operation. If the lock was free, the read returns a 0 in the lock bit, and that same access takes the lock. If the lock was already taken, the read returns 1 and changes nothing. The agent that holds the lock frees it by writing a 1 to the lock bit.

A read therefore has a side effect. The side effect happens only on a qualified read strobe, so an idle or speculative bus cycle cannot acquire the lock. The `lock_held` output follows the lock state and can gate access to the shared peripheral. The block does not identify agents, give any fairness guarantee or time out a holder. Retry policy and timeouts are left to software.

Read data is registered. It appears on `bus_rdata` in the cycle after the read strobe and holds there until the next read strobe.

Top module: `hw_semaphore`

## Requirements
- R1: After synchronous reset, `lock_held` is 0 and `bus_rdata` is 0x00.
- R2: A read strobe at the status offset (0x08) while the lock is free returns 0 in bit 0 of `bus_rdata` in the next cycle. In that same next cycle, `lock_held` is 1.
- R3: A read strobe at the status offset while the lock is held returns 1 in bit 0 of `bus_rdata` in the next cycle, and the lock stays held.
- R4: A write strobe at the status offset with bit 0 of the write data equal to 1 clears `lock_held` in the next cycle.
- R5: A write at the status offset with bit 0 equal to 0 leaves the lock unchanged. This holds whatever values the other seven data bits carry.
- R6: If a read strobe and a releasing write both hit the status offset in the same cycle, the release is applied first. The read then returns 0 in bit 0, and the lock is held afterwards.
- R7: Without a read or write strobe at the status offset, the lock does not change. This covers idle cycles, an address with no strobe, and strobes at any other offset. A read strobe at any other offset returns 0x00.
- R8: Bits 7 to 1 of `bus_rdata` are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 8 | Write data |
| bus_wr_en | input | 1 | Qualified write strobe, one cycle per write |
| bus_rd_en | input | 1 | Qualified read strobe, one cycle per read; reads have a side effect |
| bus_rdata | output | 8 | Registered read data, valid the cycle after a read strobe |
| lock_held | output | 1 | High while the semaphore is taken |

## Verification
The hardest case to reach from the ports is the collision in R6. It needs a read and a releasing write at the status offset in the same clock, both while the lock is held and while it is free. The bench drives both strobes together in one cycle to reach it.

The bench also covers writes that must be ignored (R5 and R7). It follows each such write with a read, which brings out through the read data whether the lock was disturbed. A behavioural model predicts `lock_held` and `bus_rdata` after every clock, and the bench compares both.

// File: rtl/hw_semaphore_pkg.sv
package hw_semaphore_pkg;

    localparam int unsigned SEM_ADDR_W   = 8;
    localparam int unsigned SEM_DATA_W   = 8;
    localparam logic [7:0]  SEM_STATUS_OFS = 8'h08;
    localparam int unsigned SEM_LOCK_BIT = 0;

    // Decoded bus command for one cycle
    typedef struct packed {
        logic rd_any;    // any qualified read strobe
        logic rd_hit;    // qualified read at the status offset
        logic release_q; // qualified write at the status offset carrying a 1 in the lock bit
    } sem_cmd_t;

    typedef enum logic {
        SEM_FREE = 1'b0,
        SEM_TAKEN = 1'b1
    } sem_state_e;

    function automatic logic lock_field(input logic [SEM_DATA_W-1:0] word);
        return word[SEM_LOCK_BIT];
    endfunction

endpackage

// File: rtl/hw_semaphore_decode.sv
module hw_semaphore_decode
    import hw_semaphore_pkg::*;
#(
    parameter int unsigned ADDR_W = SEM_ADDR_W,
    parameter int unsigned DATA_W = SEM_DATA_W,
    parameter logic [ADDR_W-1:0] STATUS_OFS = ADDR_W'(SEM_STATUS_OFS)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output sem_cmd_t          cmd
);

    logic at_status;

    always_comb begin
        at_status     = (addr == STATUS_OFS);
        cmd.rd_any    = rd_en;
        cmd.rd_hit    = rd_en & at_status;
        cmd.release_q = wr_en & at_status & lock_field(wdata);
    end

endmodule

// File: rtl/hw_semaphore_cell.sv
module hw_semaphore_cell
    import hw_semaphore_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sem_cmd_t cmd,
    output logic     held,
    output logic     read_view
);

    sem_state_e state_q;
    sem_state_e state_d;

    // The release is applied before the read, so a colliding read sees a free lock
    always_comb begin
        read_view = (state_q == SEM_TAKEN) & ~cmd.release_q;
        state_d   = state_q;
        if (cmd.release_q) state_d = SEM_FREE;
        if (cmd.rd_hit)    state_d = SEM_TAKEN;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEM_FREE;
        else     state_q <= state_d;
    end

    assign held = (state_q == SEM_TAKEN);

    // R2, R3, R6: a status read always leaves the lock taken
    assert_read_takes_R2: assert property (@(posedge clk) disable iff (rst)
        cmd.rd_hit |=> held);

    // R4: a release with no colliding read frees the lock
    assert_release_frees_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd.release_q && !cmd.rd_hit) |=> !held);

    // R5, R7: no status strobe, no change
    assert_idle_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (!cmd.rd_hit && !cmd.release_q) |=> $stable(held));

endmodule

// File: rtl/hw_semaphore_rdata.sv
module hw_semaphore_rdata
    import hw_semaphore_pkg::*;
#(
    parameter int unsigned DATA_W   = SEM_DATA_W,
    parameter int unsigned LOCK_BIT = SEM_LOCK_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  sem_cmd_t          cmd,
    input  logic              lock_view,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] rdata_d;
    logic [DATA_W-1:0] rdata_q;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == LOCK_BIT) begin : g_lock
            assign rdata_d[i] = cmd.rd_hit & lock_view;
        end else begin : g_zero
            assign rdata_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             rdata_q <= '0;
        else if (cmd.rd_any) rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    // R8: only the lock bit may ever read as one
    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(rdata) <= 1 && (rdata == '0 || rdata[LOCK_BIT]));

    // R7: a read elsewhere returns all zeros
    assert_other_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd.rd_any && !cmd.rd_hit) |=> (rdata == '0));

endmodule

// File: rtl/hw_semaphore.sv
module hw_semaphore
    import hw_semaphore_pkg::*;
#(
    parameter int unsigned ADDR_W   = SEM_ADDR_W,
    parameter int unsigned DATA_W   = SEM_DATA_W,
    parameter logic [ADDR_W-1:0] STATUS_OFS = ADDR_W'(SEM_STATUS_OFS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              lock_held
);

    sem_cmd_t cmd;
    logic     view;

    hw_semaphore_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_OFS(STATUS_OFS)
    ) decode_i (
        .addr(bus_addr), .wdata(bus_wdata), .wr_en(bus_wr_en),
        .rd_en(bus_rd_en), .cmd(cmd)
    );

    hw_semaphore_cell cell_i (
        .clk(clk), .rst(rst), .cmd(cmd), .held(lock_held), .read_view(view)
    );

    hw_semaphore_rdata #(
        .DATA_W(DATA_W), .LOCK_BIT(SEM_LOCK_BIT)
    ) rdata_i (
        .clk(clk), .rst(rst), .cmd(cmd), .lock_view(view), .rdata(bus_rdata)
    );

    // R3: a status read of a held lock with no release returns one
    assert_held_reads_one_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && bus_addr == STATUS_OFS && lock_held &&
         !(bus_wr_en && bus_wdata[SEM_LOCK_BIT])) |=> bus_rdata[SEM_LOCK_BIT]);

    // R2, R6: a status read of a free or just-released lock returns zero
    assert_free_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && bus_addr == STATUS_OFS &&
         (!lock_held || (bus_wr_en && bus_wdata[SEM_LOCK_BIT]))) |=> !bus_rdata[SEM_LOCK_BIT]);

endmodule

// File: tb/hw_semaphore_tb_top.sv
`timescale 1ns/1ps
module hw_semaphore_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       bus_wr_en;
    logic       bus_rd_en;
    logic [7:0] bus_rdata;
    logic       lock_held;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // reference model state
    bit         m_lock  = 1'b0;
    logic [7:0] m_rdata = 8'h00;

    always #2.5 clk = ~clk;

    hw_semaphore dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_rdata(bus_rdata), .lock_held(lock_held)
    );

    task automatic compare(input string tag);
        checks++;
        if (lock_held !== m_lock) begin
            failures++;
            $display("FAIL %s lock_held actual=%0b expected=%0b", tag, lock_held, m_lock);
        end
        checks++;
        if (bus_rdata !== m_rdata) begin
            failures++;
            $display("FAIL %s bus_rdata actual=%02h expected=%02h", tag, bus_rdata, m_rdata);
        end
    endtask

    // one bus cycle: drive at negedge, model the edge, compare at next negedge
    task automatic cycle(input string tag, input logic [7:0] a, input logic [7:0] wd,
                         input bit wr, input bit rd);
        bit rel;
        bit hit;
        bus_addr  = a;
        bus_wdata = wd;
        bus_wr_en = wr;
        bus_rd_en = rd;
        rel = wr && (a == 8'h08) && wd[0];
        hit = rd && (a == 8'h08);
        if (rd) m_rdata = hit ? {7'b0, (m_lock && !rel)} : 8'h00;
        if (rel) m_lock = 1'b0;
        if (hit) m_lock = 1'b1;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bus_wr_en = 1'b0;
        bus_rd_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_lock  = 1'b0;
        m_rdata = 8'h00;
    endtask

    initial begin
        bus_addr = 8'h00;
        bus_wdata = 8'h00;
        @(negedge clk);
        do_reset();
        compare("R1 reset");

        cycle("R7 idle", 8'h08, 8'h01, 0, 0);
        cycle("R7 read other offset", 8'h0c, 8'h00, 0, 1);
        cycle("R7 read other offset", 8'h09, 8'h00, 0, 1);
        cycle("R2 acquire free", 8'h08, 8'h00, 0, 1);
        cycle("R3 read held", 8'h08, 8'h00, 0, 1);
        cycle("R5 write zero", 8'h08, 8'h00, 1, 0);
        cycle("R5 write upper bits", 8'h08, 8'hfe, 1, 0);
        cycle("R3 still held after R5", 8'h08, 8'h00, 0, 1);
        cycle("R7 write other offset", 8'h0c, 8'hff, 1, 0);
        cycle("R7 write other offset", 8'h09, 8'h01, 1, 0);
        cycle("R7 read other while held", 8'h04, 8'h00, 0, 1);
        cycle("R3 held after R7", 8'h08, 8'h00, 0, 1);
        cycle("R4 release", 8'h08, 8'h01, 1, 0);
        cycle("R4 release again on free", 8'h08, 8'hff, 1, 0);
        cycle("R2 acquire after release", 8'h08, 8'h00, 0, 1);
        cycle("R6 collide while held", 8'h08, 8'h01, 1, 1);
        cycle("R3 held after collision", 8'h08, 8'h00, 0, 1);
        cycle("R4 release", 8'h08, 8'h01, 1, 0);
        cycle("R6 collide while free", 8'h08, 8'h01, 1, 1);
        cycle("R8 read held upper zero", 8'h08, 8'h00, 0, 1);
        for (int i = 0; i < 12; i++) begin
            cycle("R8 mixed traffic", (i % 3 == 0) ? 8'h08 : 8'(i), 8'(i * 37),
                  (i % 2) == 1, (i % 4) != 1);
        end
        cycle("R4 release", 8'h08, 8'h01, 1, 0);
        cycle("R2 acquire", 8'h08, 8'h00, 0, 1);
        do_reset();
        compare("R1 reset while held");
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule